// File: doc/BRIEF.md
# Full-Period Scrambled DMA Address Walker

This block produces the address stream for a DMA engine that must touch every location of a 512-entry window exactly once per pass, with no requirement that the locations be visited in ascending order. It does this with a shift register rather than a binary counter. Each step shifts the register one place toward the most significant bit and fills the vacated bottom bit with a feedback bit. The feedback bit is the exclusive OR of two register taps, together with one correction term. The correction term adds the all-zero address to the cycle, so the period is the full 512 and not 511.

The owner of the walker has three controls. It can preset a starting address (the seed), request one step per clock with an advance strobe, or hold the address still. A single-cycle wrap flag shows that the walk has come back to the address it started from, and so that one full pass over the window is complete. Synchronous reset starts the walk at address zero. All pins are plain control and status signals, with no handshake and no back-pressure. An advance request is always taken in the cycle it is presented.

Top module: `dma_addr_walker`

## Requirements
- R1: In the cycle after a clock edge with `rst_i` high, `addr_o` is 0 and `wrap_o` is 0.
- R2: On an edge with `rst_i`, `load_i` and `adv_i` all low, `addr_o` keeps its value and `wrap_o` is 0 afterwards.
- R3: On an edge with `load_i` high and `rst_i` low, `addr_o` takes the value of `seed_i`.
- R4: On an edge with `adv_i` high and `load_i` and `rst_i` low, the new address is `{a[7:0], a[8] ^ a[4] ^ (a[7:0] == 0)}`, where `a` is the old address. Starting from 0, the walk reads 0, 1, 2, 4, 8, 16, 33, 66, 132, 264, 17.
- R5: The all-zero address is part of the cycle. Address 256 advances to 0, and 0 advances to 1.
- R6: Starting from any seed, 512 consecutive advances visit each of the 512 addresses exactly once and end back on the seed.
- R7: `wrap_o` is high for exactly one cycle. That cycle directly follows the 512th advance counted since the last reset or load, and idle cycles between advances do not change the count. At all other times `wrap_o` is low.
- R8: If advancing continues after a wrap, `wrap_o` rises again after every further 512 advances.
- R9: When `load_i` and `adv_i` are both high on the same edge, the load takes effect and the advance is dropped. `wrap_o` is 0 in the following cycle, and the advance count starts again from the new seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high; walk restarts at address 0 |
| load_i | input | 1 | Preset the walk to `seed_i`; has priority over `adv_i` |
| seed_i | input | 9 | Starting address applied by `load_i` |
| adv_i | input | 1 | Step the walk by one address this cycle |
| addr_o | output | 9 | Current DMA address |
| wrap_o | output | 1 | One-cycle flag: walk has returned to its starting address |

## Verification
Two functions can fall into the same cycle: a preset and a step. The case that matters most is a preset that arrives on the very edge where the 512th step would have raised the wrap flag. The bench sets this up by loading a seed, taking 511 steps, and then driving `load_i` and `adv_i` together with a new seed. It expects the new seed on `addr_o` and no wrap flag. It then expects a flag exactly 512 steps after the new seed, and none earlier. A separate run spaces the steps out with idle cycles. This confirms that the flag follows the number of steps and not the number of clock cycles.

// File: rtl/walk_pkg.sv
package walk_pkg;
  // Default geometry of the walker: 9-bit address, second tap at bit 5 (1-based)
  localparam int unsigned WALK_W   = 9;
  localparam int unsigned WALK_TAP = 5;
endpackage

// File: rtl/walk_next.sv
// Next-address logic: two-tap shift feedback with optional zero insertion.
module walk_next #(
  parameter int unsigned WIDTH       = 9,
  parameter int unsigned TAP         = 5,
  parameter bit          ZERO_INSERT = 1'b1
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic tap_x;
  logic fb;

  assign tap_x = cur_i[WIDTH-1] ^ cur_i[TAP-1];

  generate
    if (ZERO_INSERT) begin : g_full
      logic low_zero;
      // all bits except the one shifted out are zero
      assign low_zero = ~|cur_i[WIDTH-2:0];
      assign fb       = tap_x ^ low_zero;
    end else begin : g_max
      assign fb = tap_x;
    end
  endgenerate

  assign nxt_o = {cur_i[WIDTH-2:0], fb};

  always_comb begin
    // R5
    if (ZERO_INSERT && cur_i == '0) zero_exit_chk: assert (nxt_o != '0);
  end
endmodule

// File: rtl/walk_state.sv
// Address register with reset, preset and step priority.
module walk_state #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       q <= '0;
    else if (load_i) q <= seed_i;
    else if (adv_i)  q <= nxt_i;
  end

  assign q_o = q;

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> q == '0);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !adv_i) |=> $stable(q));
  // R3
  load_take_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> q == $past(seed_i));
  // R4
  shift_move_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !load_i) |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
endmodule

// File: rtl/walk_wrap.sv
// Remembers the starting address and flags the return to it.
module walk_wrap #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic             wrap_o
);
  logic [WIDTH-1:0] start_q;
  logic             wrap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       start_q <= '0;
    else if (load_i) start_q <= seed_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) wrap_q <= 1'b0;
    else                 wrap_q <= adv_i && (nxt_i == start_q);
  end

  assign wrap_o = wrap_q;

  // Step counter kept only for the checks below
  localparam logic [WIDTH-1:0] CNT_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] CNT_LAST = '1;
  logic [WIDTH-1:0] chk_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) chk_cnt <= '0;
    else if (adv_i)      chk_cnt <= chk_cnt + CNT_ONE;
  end

  // R7
  wrap_on_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !load_i && chk_cnt == CNT_LAST) |=> wrap_q);
  // R7
  wrap_only_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_q |-> (chk_cnt == '0 && $past(adv_i)));
  // R9
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> !wrap_q);
endmodule

// File: rtl/dma_addr_walker.sv
// Full-period scrambled address walker for a DMA engine.
module dma_addr_walker
  import walk_pkg::*;
#(
  parameter int unsigned WIDTH = WALK_W,
  parameter int unsigned TAP   = WALK_TAP
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             adv_i,
  output logic [WIDTH-1:0] addr_o,
  output logic             wrap_o
);
  logic [WIDTH-1:0] cur;
  logic [WIDTH-1:0] nxt;

  walk_next #(.WIDTH(WIDTH), .TAP(TAP), .ZERO_INSERT(1'b1)) u_next (
    .cur_i (cur),
    .nxt_o (nxt)
  );

  walk_state #(.WIDTH(WIDTH)) u_state (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load_i),
    .adv_i  (adv_i),
    .seed_i (seed_i),
    .nxt_i  (nxt),
    .q_o    (cur)
  );

  walk_wrap #(.WIDTH(WIDTH)) u_wrap (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load_i),
    .adv_i  (adv_i),
    .seed_i (seed_i),
    .nxt_i  (nxt),
    .wrap_o (wrap_o)
  );

  assign addr_o = cur;
endmodule

// File: tb/dma_addr_walker_tb.sv
module dma_addr_walker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic       adv = 1'b0;
  logic [8:0] seed = '0;
  logic [8:0] addr;
  logic       wrap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dma_addr_walker u_dut (
    .clk_i  (clk),
    .rst_i  (rst),
    .load_i (load),
    .seed_i (seed),
    .adv_i  (adv),
    .addr_o (addr),
    .wrap_o (wrap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at falling edge, sample just after the rising edge
  task automatic step(input bit ld, input bit ad, input logic [8:0] sd);
    @(negedge clk);
    load = ld; adv = ad; seed = sd;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; load = 1'b0; adv = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    chk(addr == 9'd0, "R1 addr", int'(addr), 0);
    chk(wrap == 1'b0, "R1 wrap", int'(wrap), 0);
  endtask

  task automatic t_seq_zero();
    int exp_seq [11] = '{0, 1, 2, 4, 8, 16, 33, 66, 132, 264, 17};
    t_reset();
    for (int i = 1; i < 11; i++) begin
      step(1'b0, 1'b1, 9'd0);
      chk(int'(addr) == exp_seq[i], "R4 sequence", int'(addr), exp_seq[i]);
    end
  endtask

  task automatic t_hold();
    step(1'b1, 1'b0, 9'h0A5);
    chk(addr == 9'h0A5, "R3 load", int'(addr), 'h0A5);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 9'h1FF);
      chk(addr == 9'h0A5, "R2 hold addr", int'(addr), 'h0A5);
      chk(wrap == 1'b0, "R2 hold wrap", int'(wrap), 0);
    end
    step(1'b1, 1'b0, 9'h1FF);
    chk(addr == 9'h1FF, "R3 load ones", int'(addr), 'h1FF);
  endtask

  task automatic t_zero_insert();
    step(1'b1, 1'b0, 9'd256);
    step(1'b0, 1'b1, 9'd0);
    chk(addr == 9'd0, "R5 256 to 0", int'(addr), 0);
    step(1'b0, 1'b1, 9'd0);
    chk(addr == 9'd1, "R5 0 to 1", int'(addr), 1);
  endtask

  task automatic t_full(input logic [8:0] sd);
    bit seen [512];
    int dup = 0;
    int early = 0;
    step(1'b1, 1'b0, sd);
    seen[sd] = 1'b1;
    for (int i = 1; i <= 512; i++) begin
      step(1'b0, 1'b1, 9'd0);
      if (i < 512) begin
        if (seen[addr]) dup++;
        seen[addr] = 1'b1;
        if (wrap) early++;
      end
    end
    chk(dup == 0, "R6 no repeat", dup, 0);
    chk(early == 0, "R7 no early wrap", early, 0);
    chk(addr == sd, "R6 back to seed", int'(addr), int'(sd));
    chk(wrap == 1'b1, "R7 wrap after 512", int'(wrap), 1);
    step(1'b0, 1'b0, 9'd0);
    chk(wrap == 1'b0, "R7 wrap one cycle", int'(wrap), 0);
  endtask

  task automatic t_gap_wrap();
    int early = 0;
    step(1'b1, 1'b0, 9'h0C3);
    for (int i = 1; i <= 512; i++) begin
      step(1'b0, 1'b1, 9'd0);
      if (i < 512 && wrap) early++;
      step(1'b0, 1'b0, 9'd0);
      if (wrap) early++;
    end
    chk(early == 0, "R7 gapped no early wrap", early, 0);
    chk(addr == 9'h0C3, "R7 gapped return", int'(addr), 'h0C3);
    early = 0;
    for (int i = 1; i <= 512; i++) begin
      step(1'b0, 1'b1, 9'd0);
      if (i < 512 && wrap) early++;
    end
    chk(early == 0, "R8 second pass no early wrap", early, 0);
    chk(wrap == 1'b1, "R8 second wrap", int'(wrap), 1);
  endtask

  task automatic t_collision();
    int early = 0;
    step(1'b1, 1'b0, 9'h033);
    for (int i = 0; i < 511; i++) step(1'b0, 1'b1, 9'd0);
    step(1'b1, 1'b1, 9'h144);
    chk(addr == 9'h144, "R9 load wins", int'(addr), 'h144);
    chk(wrap == 1'b0, "R9 no wrap on load", int'(wrap), 0);
    for (int i = 1; i <= 512; i++) begin
      step(1'b0, 1'b1, 9'd0);
      if (i < 512 && wrap) early++;
    end
    chk(early == 0, "R9 count restarted", early, 0);
    chk(wrap == 1'b1, "R9 wrap from new seed", int'(wrap), 1);
  endtask

  task automatic t_reset_period();
    int early = 0;
    t_reset();
    for (int i = 1; i <= 512; i++) begin
      step(1'b0, 1'b1, 9'd0);
      if (i < 512 && wrap) early++;
    end
    chk(early == 0, "R7 reset pass no early wrap", early, 0);
    chk(wrap == 1'b1 && addr == 9'd0, "R7 wrap after reset", int'(addr), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_seq_zero();
    t_hold();
    t_zero_insert();
    t_full(9'd0);
    t_full(9'h155);
    t_full(9'h1FF);
    t_gap_wrap();
    t_collision();
    t_reset_period();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule